// File: doc/BRIEF.md
# Audio Link Reset Controller

This block owns the active-low reset pin of a serial audio codec link and the levels of the other link pads while the system moves through reset and sleep states. A global control register, written by software, holds a cold-reset bit and a link shut-off bit. The reset pin tracks the cold-reset bit. Several hardware events clear that bit and pull the pin low: a resume-well reset, a core/bus reset, a hard-reset port strobe, and entry into a deep sleep state.

Only a software write can release the link from reset, and such a write has no effect while the system is suspended. The data-out and sync outputs from the frame logic are gated to a defined low level whenever the bus is in reset or the system is not fully awake. The link shut-off bit alone controls the pull-down enables of the bit-clock pad and the serial data-in pads.

Top module: `codec_link_rst_ctrl`

## Requirements
- R1: While `rsm_rst_n` is low, `link_rst_n` is 0 without waiting for a clock edge, and the register reads all zeros.
- R2: While `core_rst_n` is low, the register reads all zeros. `link_rst_n` is 0 from the next clock edge on. `link_sdout` and `link_sync` are 0.
- R3: A one-cycle pulse on `hard_rst_wr` clears the whole register. `link_rst_n` is 0 after that clock edge.
- R4: In S0 (`sleep_state` = 0), writing 1 to bit 1 of the register sets the cold-reset bit at the write's clock edge. `link_rst_n` goes to 1 at the next clock edge. Writing 0 to bit 1 brings the pin back to 0 by the same timing.
- R5: Hardware never sets the cold-reset bit. After any reset, or after a return from suspend, bit 1 reads 0 until software writes 1 to it.
- R6: In S1 (`sleep_state` = 1), `link_rst_n` follows the cold-reset bit with the same timing as in S0.
- R7: In S3 (`sleep_state` = 2) and S4/S5 (`sleep_state` = 3), the cold-reset bit is cleared and `link_rst_n` is 0 from the first clock edge on. A write of 1 to bit 1 during these states leaves bit 1 at 0 and the pin at 0.
- R8: After a return from S3 or S4/S5 to S0, bit 1 reads 0 and `link_rst_n` stays 0 until software writes 1 to bit 1.
- R9: `link_sdout` and `link_sync` pass `fr_sdout` and `fr_sync` through only in S0 with both resets released. In every other case they are 0.
- R10: Bit 3 of the register is the link shut-off bit. It is writable in every sleep state. `bclk_pd_en` and every bit of `sdin_pd_en` equal this bit.
- R11: `rd_data` returns the register value. Only bits 1 and 3 are implemented. Every other bit reads 0, whatever value was written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both reset domains |
| rsm_rst_n | input | 1 | Resume-well reset, active low, asynchronous; implies a core reset |
| core_rst_n | input | 1 | Core/bus reset, active low, asynchronous |
| hard_rst_wr | input | 1 | One-cycle strobe for a hard-reset port write |
| sleep_state | input | 2 | 0 = S0, 1 = S1, 2 = S3, 3 = S4/S5 |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Register write data |
| rd_data | output | REG_W | Current register value |
| fr_sdout | input | 1 | Data-out from the frame logic |
| fr_sync | input | 1 | Sync from the frame logic |
| link_rst_n | output | 1 | Link reset pin, active low |
| link_sdout | output | 1 | Gated data-out pad |
| link_sync | output | 1 | Gated sync pad |
| bclk_pd_en | output | 1 | Bit-clock pad pull-down enable |
| sdin_pd_en | output | NUM_SDIN | Serial data-in pad pull-down enables |

## Verification
The bench uses the default build: a 32-bit register, cold-reset bit 1, shut-off bit 3 and two data-in pads. The register is small enough to sweep every sleep state against both cold-reset values, both shut-off values and both frame-data levels. Each of these combinations is followed by a return to S0, so the wake behaviour is reached from every state. Filler ones in the unimplemented write bits exercise the read mask. Hard-reset, core-reset and resume-reset events are each applied with the link released, so each one can be seen to pull the pin.

// File: rtl/clrc_pkg.sv
package clrc_pkg;

   typedef enum logic [1:0] {
      SLP_S0  = 2'd0,
      SLP_S1  = 2'd1,
      SLP_S3  = 2'd2,
      SLP_S45 = 2'd3
   } slp_e;

   function automatic logic slp_is_susp(input logic [1:0] s);
      return (s == SLP_S3) || (s == SLP_S45);
   endfunction

   function automatic logic slp_is_awake(input logic [1:0] s);
      return s == SLP_S0;
   endfunction

endpackage

// File: rtl/clrc_ctrl_reg.sv
module clrc_ctrl_reg #(
   parameter int REG_W    = 32,
   parameter int COLD_BIT = 1,
   parameter int SHUT_BIT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hard_rst_wr,
   input  logic             suspend,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] reg_q,
   output logic             cold_bit,
   output logic             shut_bit
);

   localparam logic [REG_W-1:0] ONE       = {{(REG_W-1){1'b0}}, 1'b1};
   localparam logic [REG_W-1:0] IMPL_MASK = (ONE << COLD_BIT) | (ONE << SHUT_BIT);

   generate
      if (COLD_BIT >= REG_W || SHUT_BIT >= REG_W)
         $error("clrc_ctrl_reg: control bit outside register");
      if (COLD_BIT == SHUT_BIT)
         $error("clrc_ctrl_reg: cold and shut-off bits overlap");
   endgenerate

   logic [REG_W-1:0] nxt;

   always_comb begin
      nxt = reg_q;
      if (wr_en)
         nxt = wr_data & IMPL_MASK;
      if (suspend)
         nxt[COLD_BIT] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         reg_q <= '0;
      else if (hard_rst_wr)
         reg_q <= '0;
      else
         reg_q <= nxt;
   end

   assign cold_bit = reg_q[COLD_BIT];
   assign shut_bit = reg_q[SHUT_BIT];

   AST_NO_HW_SET: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_data[COLD_BIT] && !suspend) |=> !$rose(cold_bit)); // R5
   AST_SUSP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      suspend |=> !cold_bit); // R7
   AST_SHUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !hard_rst_wr) |=> (shut_bit == $past(wr_data[SHUT_BIT]))); // R10
   AST_HARD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      hard_rst_wr |=> (reg_q == '0)); // R3

endmodule

// File: rtl/clrc_rst_drv.sv
module clrc_rst_drv (
   input  logic clk,
   input  logic rsm_rst_n,
   input  logic core_ok,
   input  logic hard_rst_wr,
   input  logic suspend,
   input  logic cold_bit,
   output logic link_rst_n
);

   logic release_ok;

   assign release_ok = cold_bit && core_ok && !suspend && !hard_rst_wr;

   always_ff @(posedge clk or negedge rsm_rst_n) begin
      if (!rsm_rst_n)
         link_rst_n <= 1'b0;
      else
         link_rst_n <= release_ok;
   end

   AST_RISE_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rsm_rst_n)
      $rose(link_rst_n) |-> $past(cold_bit)); // R4
   AST_SUSP_LINK_LOW: assert property (@(posedge clk) disable iff (!rsm_rst_n)
      suspend |=> !link_rst_n); // R7
   AST_HARD_LINK_LOW: assert property (@(posedge clk) disable iff (!rsm_rst_n)
      hard_rst_wr |=> !link_rst_n); // R3
   AST_CORE_LINK_LOW: assert property (@(posedge clk) disable iff (!rsm_rst_n)
      !core_ok |=> !link_rst_n); // R2

endmodule

// File: rtl/clrc_pad_ctrl.sv
module clrc_pad_ctrl
   import clrc_pkg::*;
#(
   parameter int NUM_SDIN = 2
) (
   input  logic                core_ok,
   input  logic [1:0]          sleep_state,
   input  logic                fr_sdout,
   input  logic                fr_sync,
   input  logic                shut_bit,
   output logic                link_sdout,
   output logic                link_sync,
   output logic                bclk_pd_en,
   output logic [NUM_SDIN-1:0] sdin_pd_en
);

   generate
      if (NUM_SDIN < 1 || NUM_SDIN > 8)
         $error("clrc_pad_ctrl: NUM_SDIN out of range");
   endgenerate

   logic drive_ok;

   assign drive_ok   = core_ok && slp_is_awake(sleep_state);
   assign link_sdout = drive_ok && fr_sdout;
   assign link_sync  = drive_ok && fr_sync;
   assign bclk_pd_en = shut_bit;

   generate
      for (genvar i = 0; i < NUM_SDIN; i++) begin : g_sdin_pd
         assign sdin_pd_en[i] = shut_bit;
      end
   endgenerate

endmodule

// File: rtl/codec_link_rst_ctrl.sv
module codec_link_rst_ctrl
   import clrc_pkg::*;
#(
   parameter int REG_W    = 32,
   parameter int COLD_BIT = 1,
   parameter int SHUT_BIT = 3,
   parameter int NUM_SDIN = 2
) (
   input  logic                clk,
   input  logic                rsm_rst_n,
   input  logic                core_rst_n,
   input  logic                hard_rst_wr,
   input  logic [1:0]          sleep_state,
   input  logic                wr_en,
   input  logic [REG_W-1:0]    wr_data,
   output logic [REG_W-1:0]    rd_data,
   input  logic                fr_sdout,
   input  logic                fr_sync,
   output logic                link_rst_n,
   output logic                link_sdout,
   output logic                link_sync,
   output logic                bclk_pd_en,
   output logic [NUM_SDIN-1:0] sdin_pd_en
);

   logic core_ok;
   logic suspend;
   logic cold_bit;
   logic shut_bit;

   assign core_ok = core_rst_n && rsm_rst_n;
   assign suspend = slp_is_susp(sleep_state);

   clrc_ctrl_reg #(
      .REG_W   (REG_W),
      .COLD_BIT(COLD_BIT),
      .SHUT_BIT(SHUT_BIT)
   ) i_ctrl_reg (
      .clk        (clk),
      .rst_n      (core_ok),
      .hard_rst_wr(hard_rst_wr),
      .suspend    (suspend),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .reg_q      (rd_data),
      .cold_bit   (cold_bit),
      .shut_bit   (shut_bit)
   );

   clrc_rst_drv i_rst_drv (
      .clk        (clk),
      .rsm_rst_n  (rsm_rst_n),
      .core_ok    (core_ok),
      .hard_rst_wr(hard_rst_wr),
      .suspend    (suspend),
      .cold_bit   (cold_bit),
      .link_rst_n (link_rst_n)
   );

   clrc_pad_ctrl #(
      .NUM_SDIN(NUM_SDIN)
   ) i_pad_ctrl (
      .core_ok    (core_ok),
      .sleep_state(sleep_state),
      .fr_sdout   (fr_sdout),
      .fr_sync    (fr_sync),
      .shut_bit   (shut_bit),
      .link_sdout (link_sdout),
      .link_sync  (link_sync),
      .bclk_pd_en (bclk_pd_en),
      .sdin_pd_en (sdin_pd_en)
   );

   AST_PADS_QUIET: assert property (@(posedge clk) disable iff (!rsm_rst_n)
      (sleep_state != SLP_S0) |-> (!link_sdout && !link_sync)); // R9
   AST_WAKE_HELD: assert property (@(posedge clk) disable iff (!rsm_rst_n)
      ($past(suspend) && !suspend && !link_rst_n) |=> !link_rst_n); // R8
   AST_PD_MATCH: assert property (@(posedge clk) disable iff (!rsm_rst_n)
      $past(wr_en && core_ok && !hard_rst_wr) |-> (bclk_pd_en == $past(wr_data[SHUT_BIT]))); // R10

endmodule

// File: tb/test_codec_link_rst_ctrl.sv
`timescale 1ns/1ps
module test_codec_link_rst_ctrl;

   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rsm_rst_n, core_rst_n, hard_rst_wr, wr_en, fr_sdout, fr_sync;
   logic [1:0]   sleep_state;
   logic [W-1:0] wr_data, rd_data;
   logic         link_rst_n, link_sdout, link_sync, bclk_pd_en;
   logic [1:0]   sdin_pd_en;

   int n_tests = 0;
   int n_fail  = 0;
   logic m_cold = 1'b0, m_shut = 1'b0, m_link = 1'b0;

   always #2.5 clk = ~clk;

   codec_link_rst_ctrl i_codec_link_rst_ctrl (
      .clk(clk), .rsm_rst_n(rsm_rst_n), .core_rst_n(core_rst_n),
      .hard_rst_wr(hard_rst_wr), .sleep_state(sleep_state), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .fr_sdout(fr_sdout), .fr_sync(fr_sync),
      .link_rst_n(link_rst_n), .link_sdout(link_sdout), .link_sync(link_sync),
      .bclk_pd_en(bclk_pd_en), .sdin_pd_en(sdin_pd_en)
   );

   task automatic chk(input string req, input string what, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // one clock edge with a requirement-level model of the register and pin
   task automatic cyc;
      logic ok, susp, prev_cold;
      @(posedge clk);
      ok        = core_rst_n && rsm_rst_n;
      susp      = sleep_state[1];
      prev_cold = m_cold;
      if (!ok) begin
         m_cold = 1'b0; m_shut = 1'b0;
      end else if (hard_rst_wr) begin
         m_cold = 1'b0; m_shut = 1'b0;
      end else begin
         if (wr_en) begin
            m_cold = wr_data[1]; m_shut = wr_data[3];
         end
         if (susp) m_cold = 1'b0;
      end
      m_link = rsm_rst_n && prev_cold && !susp && ok && !hard_rst_wr;
      @(negedge clk);
   endtask

   task automatic check_all(input string link_req);
      logic ok;
      logic [W-1:0] exp_rd;
      ok     = core_rst_n && rsm_rst_n;
      exp_rd = '0;
      exp_rd[1] = m_cold;
      exp_rd[3] = m_shut;
      chk(link_req, "link_rst_n", {31'd0, link_rst_n}, {31'd0, m_link});
      chk("R11", "rd_data", rd_data, exp_rd);
      chk("R9", "sdout/sync", {30'd0, link_sdout, link_sync},
          {30'd0, fr_sdout && ok && sleep_state == 2'd0, fr_sync && ok && sleep_state == 2'd0});
      chk("R10", "pulldowns", {29'd0, bclk_pd_en, sdin_pd_en}, {29'd0, {3{m_shut}}});
   endtask

   task automatic wr(input logic [W-1:0] d);
      wr_en = 1'b1; wr_data = d;
      cyc;
      wr_en = 1'b0; wr_data = '0;
   endtask

   initial begin
      #(5.0 * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      rsm_rst_n = 1'b0; core_rst_n = 1'b0; hard_rst_wr = 1'b0; wr_en = 1'b0;
      wr_data = '0; sleep_state = 2'd0; fr_sdout = 1'b1; fr_sync = 1'b1;
      #1;
      chk("R1", "link during resume reset", {31'd0, link_rst_n}, '0);
      chk("R1", "reg during resume reset", rd_data, '0);
      cyc; cyc;
      check_all("R1");
      rsm_rst_n = 1'b1; core_rst_n = 1'b1;
      cyc; cyc; cyc;
      check_all("R5");
      chk("R5", "cold bit after reset", {31'd0, rd_data[1]}, '0);

      // sweep all states, cold values, shut-off values and frame levels
      for (int s = 0; s < 4; s++) begin
         for (int c = 0; c < 2; c++) begin
            for (int h = 0; h < 2; h++) begin
               string tag;
               tag = (s == 0) ? "R4" : (s == 1) ? "R6" : "R7";
               // release from S0 first so suspend has something to pull down
               sleep_state = 2'd0;
               wr(32'hA5A5_A5A6);
               cyc;
               sleep_state = s[1:0];
               fr_sdout = c[0]; fr_sync = h[0];
               cyc;
               check_all(tag);
               wr(32'hF0F0_F0F0 | (W'(c) << 1) | (W'(h) << 3));
               check_all(tag);
               cyc;
               check_all(tag);
               sleep_state = 2'd0;
               cyc; cyc;
               check_all((s >= 2) ? "R8" : tag);
               if (s >= 2)
                  chk("R8", "cold bit after wake", {31'd0, rd_data[1]}, '0);
            end
         end
      end

      // hard-reset strobe with the link released
      fr_sdout = 1'b1; fr_sync = 1'b1;
      wr(32'h0000_000A); cyc;
      chk("R4", "link released", {31'd0, link_rst_n}, 32'd1);
      hard_rst_wr = 1'b1; cyc; hard_rst_wr = 1'b0;
      check_all("R3");
      chk("R3", "link after hard reset", {31'd0, link_rst_n}, '0);
      cyc; cyc;
      chk("R5", "no self release", {31'd0, link_rst_n}, '0);

      // core reset with the link released
      wr(32'h0000_000A); cyc;
      core_rst_n = 1'b0; #1;
      chk("R2", "reg during core reset", rd_data, '0);
      chk("R2", "sdout during core reset", {31'd0, link_sdout}, '0);
      @(negedge clk);
      cyc;
      check_all("R2");
      core_rst_n = 1'b1; cyc; cyc;
      check_all("R5");

      // resume reset with the link released
      wr(32'h0000_0002); cyc;
      chk("R4", "link released again", {31'd0, link_rst_n}, 32'd1);
      rsm_rst_n = 1'b0; #1;
      chk("R1", "link falls at once", {31'd0, link_rst_n}, '0);
      @(negedge clk);
      cyc;
      check_all("R1");
      rsm_rst_n = 1'b1; cyc; cyc;
      check_all("R5");

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule